// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block produces one pulse-width modulated output from a source clock. A programmable prescaler divides the clock into ticks. Each tick advances an 8-bit phase counter, so one output period lasts 256 ticks. The output is high while the phase is below an 8-bit width value. A separate flag holds the output high for the entire period. When enabled, the highest output frequency is the clock rate divided by 256.

All configuration sits in one 32-bit control word, which is written over a single-cycle write strobe and can be read back at any time. The block never waits for a period to finish. A rewrite starts a fresh period at once. Clearing the enable bit drives the output low on the next clock.

Top module: `pwm_prescaled_gen`

## Requirements
- R1: The control word holds the divider field in bits [12:0], the width field in bits [23:16], the full-on flag in bit 24 and the enable flag in bit 31. All other bits read as zero, and writes to them are discarded.
- R2: The prescaler divides the clock by the divider field plus one, so a divider field of 0 produces one tick every clock.
- R3: One output period lasts 256 ticks, which is 256 × (divider + 1) clock cycles, and the pattern repeats every period.
- R4: In each period the output is high for a number of ticks equal to the width field. Those high ticks come first in the period. A width of 0 keeps the output low.
- R5: While the full-on flag is set and the block is enabled, the output stays high and the width field has no effect.
- R6: While the enable flag is clear, the output is 0 whatever the other fields hold, and both counters are held at zero.
- R7: A write that clears the enable flag forces the output low from the very next cycle, even in the middle of a period.
- R8: Any write to the control word clears both counters. If the block is enabled, a new period begins in the cycle right after the write, using the new fields.
- R9: A synchronous active-high reset clears the control word and both counters, and drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word value to write |
| cfg_rdata | output | 32 | Current control word, with reserved bits reading as zero |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench counts high cycles across whole periods for several divider and width settings, including widths of 0 and 255. A prescaler that was off by one would give high counts that are not a multiple of divider + 1. A width compare written with `<=` would give one extra high tick, and a width of 0 would then produce a glitch.

The bench also rewrites the control word in the middle of a period and disables the block in the middle of a period. A design that waited for the period boundary would keep driving the old pattern, or stay high, for the remainder of that period.

The full-on flag is tested together with a width of 0. This catches a design that ignores the flag or lets the width field win.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Field widths
  localparam int DIV_W   = 13;
  localparam int WIDTH_W = 8;

  // Bit positions in the control word
  localparam int DIV_LSB   = 0;
  localparam int WIDTH_LSB = 16;
  localparam int FULL_BIT  = 24;
  localparam int EN_BIT    = 31;

  typedef struct packed {
    logic               en;
    logic               full;
    logic [WIDTH_W-1:0] width;
    logic [DIV_W-1:0]   div;
  } pwm_cfg_t;

  // Split a raw 32-bit word into its fields
  function automatic pwm_cfg_t unpack_cfg(input logic [31:0] w);
    pwm_cfg_t c;
    c.en    = w[EN_BIT];
    c.full  = w[FULL_BIT];
    c.width = w[WIDTH_LSB +: WIDTH_W];
    c.div   = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  // Rebuild the 32-bit word; reserved bits come out as zero
  function automatic logic [31:0] pack_cfg(input pwm_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[EN_BIT]                 = c.en;
    w[FULL_BIT]               = c.full;
    w[WIDTH_LSB +: WIDTH_W]   = c.width;
    w[DIV_LSB +: DIV_W]       = c.div;
    return w;
  endfunction

  // Output level for a given phase and configuration
  function automatic logic level_of(input pwm_cfg_t c, input logic [WIDTH_W-1:0] ph);
    return c.en && (c.full || (ph < c.width));
  endfunction
endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
  import pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output pwm_cfg_t    cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= '0;
    else if (we) cfg <= unpack_cfg(wdata);
  end

  // R9
  reset_clears_cfg_chk: assert property (@(posedge clk) rst |=> (cfg == '0));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [DIV_W-1:0] cnt
);
  logic at_end;
  assign at_end = (cnt >= div);
  assign tick   = !clear && at_end;

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt <= '0;
    else if (at_end)    cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |-> (cnt <= div));
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            tick,
  output logic [PH_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else if (tick)    phase <= phase + 1'b1;
  end

  // R3
  phase_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> $stable(phase));
endmodule

// File: rtl/pwm_prescaled_gen.sv
module pwm_prescaled_gen
  import pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        pwm_out
);
  pwm_cfg_t           cfg;
  logic               restart;
  logic               tick;
  logic [DIV_W-1:0]   pre_cnt;
  logic [WIDTH_W-1:0] phase;

  // Counters are held at zero while disabled and on any write
  assign restart = cfg_we || !cfg.en;

  pwm_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .clear(restart), .div(cfg.div),
    .tick(tick), .cnt(pre_cnt)
  );

  pwm_phase #(.PH_W(WIDTH_W)) u_ph (
    .clk(clk), .rst(rst), .clear(restart), .tick(tick), .phase(phase)
  );

  assign cfg_rdata = pack_cfg(cfg);
  assign pwm_out   = level_of(cfg, phase);

  // R8
  write_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (phase == '0 && pre_cnt == '0));
  // R6
  off_is_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[EN_BIT] |-> !pwm_out);
  // R5
  full_is_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[EN_BIT] && cfg_rdata[FULL_BIT]) |-> pwm_out);
  // R4
  zero_width_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rdata[FULL_BIT] && cfg_rdata[WIDTH_LSB +: WIDTH_W] == '0) |-> !pwm_out);
  // R7
  disable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_wdata[EN_BIT]) |=> !pwm_out);
endmodule

// File: tb/pwm_prescaled_gen_tb.sv
module pwm_prescaled_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        pwm_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_prescaled_gen dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pwm_out(pwm_out)
  );

  // Stimulus word: en bit31, full bit24, width [23:16], divider [12:0]
  localparam logic [31:0] VEC [8] = '{
    32'h8080_0000, 32'h8000_0000, 32'h80FF_0000, 32'h8040_0001,
    32'h8005_0003, 32'h81FF_0002, 32'h8100_0000, 32'h8001_0004
  };
  localparam int EXP_HIGH [8] = '{128, 0, 255, 128, 20, 768, 256, 5};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; write lands on the next posedge, returns at the following negedge
  task automatic wr(input logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Count high samples over n cycles, sampling at negedges
  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    int per;
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 rdata", cfg_rdata, 32'h0);
    check("R9 out", {31'b0, pwm_out}, 32'h0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      wr(VEC[v]);
      per = 256 * (int'(VEC[v][12:0]) + 1);
      count_high(per, hi);
      check("R4/R2 period high count", hi, EXP_HIGH[v]);
      count_high(per, hi);
      check("R3 next period repeats", hi, EXP_HIGH[v]);
    end

    // R1: reserved bits dropped
    wr(32'hFFFF_FFFF);
    check("R1 readback", cfg_rdata, 32'h81FF_1FFF);
    check("R5 full on", {31'b0, pwm_out}, 32'h1);

    // R6: disabled with full set stays low
    wr(32'h01FF_0000);
    count_high(300, hi);
    check("R6 disabled low", hi, 0);

    // R8: rewrite mid-period restarts at once
    wr(32'h80FF_0000);
    repeat (200) @(negedge clk);
    wr(32'h800A_0000);
    check("R8 first cycle high", {31'b0, pwm_out}, 32'h1);
    count_high(256, hi);
    check("R8 restarted high count", hi, 10);

    // R7: disable mid-period cuts output
    wr(32'h80FF_0000);
    repeat (50) @(negedge clk);
    check("R7 high before disable", {31'b0, pwm_out}, 32'h1);
    wr(32'h00FF_0000);
    check("R7 low right after disable", {31'b0, pwm_out}, 32'h0);

    // R9: reset mid-run
    wr(32'h8100_0000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset clears cfg", cfg_rdata, 32'h0);
    check("R9 reset out low", {31'b0, pwm_out}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule